// File: doc/BRIEF.md
# Quad-Lane Dual-Width Byte FIFO

This block is the data buffer between a host register port and a byte-serial shift engine. Its storage is four byte lanes, each a 16-entry FIFO. When the host moves a 32-bit word, one byte enters or leaves every lane at once, so 64 bytes fit. When the host moves single bytes, only lane 0 is used, so 16 bytes fit. On the serial side one byte moves per access. In word mode a lane pointer rotates 0, 1, 2, 3, so the byte stream keeps the least significant byte first. In byte mode the serial side also uses lane 0 only.

The same instance serves either direction. For transmit, the host writes and the serial engine pops. For receive, the serial engine pushes and the host reads. The width mode is chosen once per transfer: word mode when the length is a multiple of four, byte mode otherwise. The mode changes only together with a soft clear. Occupancy is tracked by a three-state machine with the states OCC_EMPTY, OCC_PARTIAL and OCC_FULL. Its transitions are fill (EMPTY to PARTIAL), drain (PARTIAL to EMPTY), top-off (PARTIAL to FULL), release (FULL to PARTIAL) and clear (any state to EMPTY). Requests that would overflow or underflow a lane are dropped and raise a one-cycle error pulse.

Top module: `quad_lane_fifo`

## Requirements
- R1: In word mode a host write puts bits [8k+7:8k] into lane k. Serial pops then return the bytes in the order lane 0, 1, 2, 3, which for a written word 0x44332211 gives 0x11, 0x22, 0x33, 0x44.
- R2: In word mode the buffer holds 64 bytes (16 words). `full` is 1 after the 16th write, and a 17th write is dropped.
- R3: In byte mode only lane 0 is used (host bits 7:0). The buffer holds 16 bytes, `full` is 1 after the 16th byte, and serial pops return the bytes in write order.
- R4: `half_full` is 1 exactly when the byte count of the active lanes is at least half the mode's capacity: 32 in word mode, 8 in byte mode.
- R5: `empty` is 1 after reset and whenever the active lanes hold no byte. `empty` and `full` are never 1 together.
- R6: In word mode serial pushes go to lanes 0, 1, 2, 3 in turn. A host word read returns {4th, 3rd, 2nd, 1st byte pushed}.
- R7: `word_avail` is 1 only in word mode and only when all four lanes hold at least one byte. A host read while it is 0 is dropped.
- R8: `byte_avail` is 1 only in byte mode when lane 0 holds a byte. A host read in byte mode returns that byte in bits 7:0 with zeros above.
- R9: A write or push into a full lane, or a read or pop from an empty lane, is dropped and leaves the contents unchanged. `ill_acc` is 1 for exactly the one cycle after the offending request.
- R10: `soft_clr` empties every lane in one cycle and returns the serial pointer to lane 0. A request in the same cycle is ignored and raises no `ill_acc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| soft_clr | input | 1 | Synchronous clear of all lanes |
| word_mode | input | 1 | 1 = 32-bit host accesses over four lanes, 0 = byte accesses on lane 0 |
| host_wr | input | 1 | Host write request |
| host_wdata | input | 32 | Host write data |
| host_rd | input | 1 | Host read request |
| host_rdata | output | 32 | Host read data (head of the lanes, shown before the read) |
| ser_push | input | 1 | Serial-side byte push |
| ser_wdata | input | 8 | Serial push data |
| ser_pop | input | 1 | Serial-side byte pop |
| ser_rdata | output | 8 | Head byte at the serial lane pointer |
| full | output | 1 | Active lanes at capacity |
| half_full | output | 1 | Active lanes at least half full |
| empty | output | 1 | Active lanes hold nothing |
| word_avail | output | 1 | A whole word can be read |
| byte_avail | output | 1 | A byte can be read in byte mode |
| ill_acc | output | 1 | One-cycle pulse after a dropped request |

## Verification
The assertions take two things for granted. First, at most one of the four request inputs is high in any cycle. Second, `word_mode` changes only in a cycle where `soft_clr` is high, so the occupancy state never refers to a stale lane set. The stimulus meets both rules: each driver task raises one request for a single cycle and lowers it before the next. Every mode switch is made in the same cycle as a soft clear. The only deliberate overlap is a host write issued together with `soft_clr`, which the block must ignore.

// File: rtl/qlf_pkg.sv
package qlf_pkg;
    typedef enum logic [1:0] {
        OCC_EMPTY   = 2'd0,
        OCC_PARTIAL = 2'd1,
        OCC_FULL    = 2'd2
    } occ_state_e;
endpackage

// File: rtl/qlf_lane.sv
module qlf_lane #(
    parameter int BW    = 8,
    parameter int DEPTH = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clr,
    input  logic                         push,
    input  logic [BW-1:0]                din,
    input  logic                         pop,
    output logic [BW-1:0]                dout,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         full,
    output logic                         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH+1);

    logic [BW-1:0] mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_push = push && !full && !clr;
    assign do_pop  = pop && !empty && !clr;
    assign dout    = mem[rp];
    assign count   = cnt;

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else if (clr) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
            unique case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end
endmodule

// File: rtl/qlf_lane_sel.sv
module qlf_lane_sel #(
    parameter int LANES = 4,
    parameter int SW    = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          word_mode,
    input  logic          step,
    output logic [SW-1:0] sel
);
    logic [SW-1:0] ptr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (clr) begin
            ptr <= '0;
        end else if (step && word_mode) begin
            ptr <= (ptr == SW'(LANES-1)) ? '0 : ptr + 1'b1;
        end
    end

    assign sel = word_mode ? ptr : '0;
endmodule

// File: rtl/quad_lane_fifo.sv
module quad_lane_fifo
    import qlf_pkg::*;
#(
    parameter int LANES = 4,
    parameter int DEPTH = 16,
    parameter int BW    = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  soft_clr,
    input  logic                  word_mode,
    input  logic                  host_wr,
    input  logic [LANES*BW-1:0]   host_wdata,
    input  logic                  host_rd,
    output logic [LANES*BW-1:0]   host_rdata,
    input  logic                  ser_push,
    input  logic [BW-1:0]         ser_wdata,
    input  logic                  ser_pop,
    output logic [BW-1:0]         ser_rdata,
    output logic                  full,
    output logic                  half_full,
    output logic                  empty,
    output logic                  word_avail,
    output logic                  byte_avail,
    output logic                  ill_acc
);
    localparam int CW = $clog2(DEPTH+1);
    localparam int FW = $clog2(LANES*DEPTH+1);
    localparam int SW = (LANES > 1) ? $clog2(LANES) : 1;

    logic [LANES-1:0] lane_full, lane_empty, lane_push, lane_pop;
    logic [BW-1:0]    lane_din  [LANES];
    logic [BW-1:0]    lane_dout [LANES];
    logic [CW-1:0]    lane_cnt  [LANES];
    logic [SW-1:0]    sel;

    logic hw_ok, hr_ok, sp_ok, spop_ok;
    logic acc_hw, acc_hr, acc_sp, acc_spop, illegal;
    logic ill_q;
    logic [FW-1:0] fill, fill_nxt, cap, step_w;
    occ_state_e state, state_nxt;

    // request acceptance
    assign hw_ok   = word_mode ? ~|lane_full  : ~lane_full[0];
    assign hr_ok   = word_mode ? ~|lane_empty : ~lane_empty[0];
    assign sp_ok   = ~lane_full[sel];
    assign spop_ok = ~lane_empty[sel];

    assign acc_hw   = host_wr  && hw_ok   && !soft_clr;
    assign acc_hr   = host_rd  && hr_ok   && !soft_clr;
    assign acc_sp   = ser_push && sp_ok   && !soft_clr;
    assign acc_spop = ser_pop  && spop_ok && !soft_clr;
    assign illegal  = !soft_clr && ((host_wr && !hw_ok) || (host_rd && !hr_ok) ||
                                    (ser_push && !sp_ok) || (ser_pop && !spop_ok));

    genvar k;
    generate
        for (k = 0; k < LANES; k++) begin : g_lane
            assign lane_push[k] = (acc_hw && (word_mode || k == 0)) ||
                                  (acc_sp && (sel == SW'(k)));
            assign lane_pop[k]  = (acc_hr && (word_mode || k == 0)) ||
                                  (acc_spop && (sel == SW'(k)));
            assign lane_din[k]  = acc_hw ? host_wdata[k*BW +: BW] : ser_wdata;
            assign host_rdata[k*BW +: BW] = (word_mode || k == 0) ? lane_dout[k] : '0;

            qlf_lane #(.BW(BW), .DEPTH(DEPTH)) i_lane (
                .clk   (clk),
                .rst_n (rst_n),
                .clr   (soft_clr),
                .push  (lane_push[k]),
                .din   (lane_din[k]),
                .pop   (lane_pop[k]),
                .dout  (lane_dout[k]),
                .count (lane_cnt[k]),
                .full  (lane_full[k]),
                .empty (lane_empty[k])
            );
        end
    endgenerate

    qlf_lane_sel #(.LANES(LANES), .SW(SW)) i_sel (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (soft_clr),
        .word_mode (word_mode),
        .step      (acc_sp || acc_spop),
        .sel       (sel)
    );

    assign ser_rdata = lane_dout[sel];

    // occupancy of the active lanes
    always_comb begin
        fill = '0;
        for (int i = 0; i < LANES; i++) begin
            if (word_mode || i == 0) fill = fill + FW'(lane_cnt[i]);
        end
    end

    assign cap      = word_mode ? FW'(LANES*DEPTH) : FW'(DEPTH);
    assign step_w   = word_mode ? FW'(LANES) : FW'(1);
    assign fill_nxt = fill
                    + (acc_hw ? step_w : (acc_sp   ? FW'(1) : '0))
                    - (acc_hr ? step_w : (acc_spop ? FW'(1) : '0));

    // next-state logic
    always_comb begin
        state_nxt = state;
        if (soft_clr) begin
            state_nxt = OCC_EMPTY;                              // clear
        end else begin
            unique case (state)
                OCC_EMPTY:   if (fill_nxt != '0) state_nxt = OCC_PARTIAL;     // fill
                OCC_PARTIAL: begin
                    if (fill_nxt == '0)       state_nxt = OCC_EMPTY;          // drain
                    else if (fill_nxt == cap) state_nxt = OCC_FULL;           // top-off
                end
                OCC_FULL:    if (fill_nxt != cap) state_nxt = OCC_PARTIAL;    // release
                default:     state_nxt = OCC_EMPTY;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= OCC_EMPTY;
            ill_q <= 1'b0;
        end else begin
            state <= state_nxt;
            ill_q <= illegal;
        end
    end

    // outputs
    always_comb begin
        empty      = (state == OCC_EMPTY);
        full       = (state == OCC_FULL);
        half_full  = (fill >= (cap >> 1)) && (fill != '0);
        word_avail = word_mode && !(|lane_empty);
        byte_avail = !word_mode && !lane_empty[0];
        ill_acc    = ill_q;
    end
endmodule

// File: rtl/quad_lane_fifo_chk.sv
module quad_lane_fifo_chk (
    input logic clk,
    input logic rst_n,
    input logic soft_clr,
    input logic word_mode,
    input logic host_wr,
    input logic host_rd,
    input logic ser_push,
    input logic ser_pop,
    input logic full,
    input logic half_full,
    input logic empty,
    input logic word_avail,
    input logic byte_avail,
    input logic ill_acc
);
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (full && word_mode && host_wr && !soft_clr) |=> ill_acc); // R2
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && ser_pop && !soft_clr) |=> ill_acc); // R9
    AST_ILL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        ill_acc |-> $past(host_wr || host_rd || ser_push || ser_pop)); // R9
    AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        soft_clr |=> (empty && !word_avail && !byte_avail && !ill_acc)); // R10
    AST_FULL_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> half_full); // R4
    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty)); // R5
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_wr && !host_rd && !ser_push && !ser_pop && !soft_clr)
        |=> ($stable(empty) && $stable(full) && !ill_acc)); // R5
    AST_WORD_AVAIL: assert property (@(posedge clk) disable iff (!rst_n)
        word_avail |-> (word_mode && !empty)); // R7
    AST_BYTE_AVAIL: assert property (@(posedge clk) disable iff (!rst_n)
        byte_avail |-> (!word_mode && !empty)); // R8
endmodule

bind quad_lane_fifo quad_lane_fifo_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_clr   (soft_clr),
    .word_mode  (word_mode),
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .ser_push   (ser_push),
    .ser_pop    (ser_pop),
    .full       (full),
    .half_full  (half_full),
    .empty      (empty),
    .word_avail (word_avail),
    .byte_avail (byte_avail),
    .ill_acc    (ill_acc)
);

// File: tb/test_quad_lane_fifo.sv
module test_quad_lane_fifo;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_clr = 1'b0;
    logic        word_mode = 1'b1;
    logic        host_wr = 1'b0;
    logic [31:0] host_wdata = '0;
    logic        host_rd = 1'b0;
    logic [31:0] host_rdata;
    logic        ser_push = 1'b0;
    logic [7:0]  ser_wdata = '0;
    logic        ser_pop = 1'b0;
    logic [7:0]  ser_rdata;
    logic        full, half_full, empty, word_avail, byte_avail, ill_acc;

    int n_vec = 0;
    int n_bad = 0;
    logic [7:0] exp_q[$];

    always #2.5 clk = ~clk;

    quad_lane_fifo i_quad_lane_fifo (
        .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .word_mode(word_mode),
        .host_wr(host_wr), .host_wdata(host_wdata), .host_rd(host_rd),
        .host_rdata(host_rdata), .ser_push(ser_push), .ser_wdata(ser_wdata),
        .ser_pop(ser_pop), .ser_rdata(ser_rdata), .full(full),
        .half_full(half_full), .empty(empty), .word_avail(word_avail),
        .byte_avail(byte_avail), .ill_acc(ill_acc)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    // driver: host write, records accepted bytes in the scoreboard queue
    task automatic host_write(input logic [31:0] d, input bit accepted);
        host_wr = 1'b1; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
        if (accepted) begin
            if (word_mode) for (int j = 0; j < 4; j++) exp_q.push_back(d[j*8 +: 8]);
            else exp_q.push_back(d[7:0]);
        end
    endtask

    // monitor: serial pop compared with the scoreboard head
    task automatic ser_pop_chk(input string req);
        logic [7:0] e;
        ser_pop = 1'b1;
        if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            chk(req, {24'h0, ser_rdata}, {24'h0, e});
        end
        @(negedge clk);
        ser_pop = 1'b0;
    endtask

    task automatic ser_push_b(input logic [7:0] d);
        ser_push = 1'b1; ser_wdata = d;
        @(negedge clk);
        ser_push = 1'b0;
    endtask

    task automatic host_read();
        host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic clear_to(input logic mode);
        soft_clr = 1'b1; word_mode = mode;
        @(negedge clk);
        soft_clr = 1'b0;
        exp_q.delete();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R5 reset state
        chk("R5 reset empty", 32'(empty), 1);
        chk("R5 reset full", 32'(full), 0);
        chk("R4 reset half", 32'(half_full), 0);
        chk("R7 reset word_avail", 32'(word_avail), 0);
        chk("R9 reset ill", 32'(ill_acc), 0);

        // R1 lane byte order
        host_write(32'h44332211, 1);
        chk("R5 not empty", 32'(empty), 0);
        for (int i = 0; i < 4; i++) ser_pop_chk("R1 lane order");
        chk("R5 empty after drain", 32'(empty), 1);

        // R2 / R4 word capacity
        for (int i = 0; i < 16; i++) begin
            host_write({8'(i*4+3), 8'(i*4+2), 8'(i*4+1), 8'(i*4)}, 1);
            if (i == 6) chk("R4 half at 28", 32'(half_full), 0);
            if (i == 7) chk("R4 half at 32", 32'(half_full), 1);
            if (i == 14) chk("R2 not full at 60", 32'(full), 0);
        end
        chk("R2 full at 64", 32'(full), 1);
        host_write(32'hFFFFFFFF, 0);
        chk("R9 overflow pulse", 32'(ill_acc), 1);
        @(negedge clk);
        chk("R9 pulse one cycle", 32'(ill_acc), 0);
        ser_pop_chk("R2 first byte");
        chk("R2 full released", 32'(full), 0);
        for (int i = 1; i < 64; i++) ser_pop_chk("R2 drain order");
        chk("R2 dropped word absent", 32'(empty), 1);
        ser_pop = 1'b1;
        @(negedge clk);
        ser_pop = 1'b0;
        chk("R9 underflow pulse", 32'(ill_acc), 1);

        // R10 soft clear
        host_write(32'h11111111, 1);
        ser_pop_chk("R10 pre-clear pop");
        soft_clr = 1'b1; host_wr = 1'b1; host_wdata = 32'h22222222;
        @(negedge clk);
        soft_clr = 1'b0; host_wr = 1'b0;
        exp_q.delete();
        chk("R10 cleared empty", 32'(empty), 1);
        chk("R10 no ill on clear", 32'(ill_acc), 0);
        host_write(32'hDDCCBBAA, 1);
        ser_pop_chk("R10 pointer back to lane 0");

        // R3 byte mode capacity
        clear_to(1'b0);
        for (int i = 0; i < 16; i++) begin
            host_write({24'hFFFFFF, 8'(8'h80 + i)}, 1);
            if (i == 6) chk("R4 byte half at 7", 32'(half_full), 0);
            if (i == 7) chk("R4 byte half at 8", 32'(half_full), 1);
        end
        chk("R3 byte full at 16", 32'(full), 1);
        host_write(32'h000000EE, 0);
        chk("R3 overflow dropped", 32'(ill_acc), 1);
        for (int i = 0; i < 16; i++) ser_pop_chk("R3 byte order");
        chk("R3 empty after 16", 32'(empty), 1);

        // R6 / R7 receive word mode
        clear_to(1'b1);
        ser_push_b(8'hA1); ser_push_b(8'hA2); ser_push_b(8'hA3);
        chk("R7 three lanes", 32'(word_avail), 0);
        host_read();
        chk("R7 early read dropped", 32'(ill_acc), 1);
        ser_push_b(8'hA4);
        chk("R7 four lanes", 32'(word_avail), 1);
        chk("R6 word assembly", host_rdata, 32'hA4A3A2A1);
        host_read();
        chk("R6 empty after read", 32'(empty), 1);
        chk("R7 word_avail drop", 32'(word_avail), 0);

        // R8 receive byte mode
        clear_to(1'b0);
        chk("R8 none yet", 32'(byte_avail), 0);
        ser_push_b(8'h5C);
        chk("R8 byte_avail", 32'(byte_avail), 1);
        chk("R8 no word in byte mode", 32'(word_avail), 0);
        chk("R8 byte read data", host_rdata, 32'h0000005C);
        host_read();
        chk("R8 byte_avail cleared", 32'(byte_avail), 0);

        summary();
    end
endmodule